// File: doc/BRIEF.md
# Edge-Timestamping Input Capture Unit

This block timestamps transitions on up to four external digital inputs. A shared counter advances on a divided version of the system clock. Each channel watches its own input for the kind of transition that software has picked for it: none, low-to-high, high-to-low or any change. When that transition occurs, the channel copies the counter into its own capture register and raises a pending flag. Each pending flag can be routed to a single interrupt line.

Software measures the high time and the period of a pulse train from successive timestamps. It arms a channel for low-to-high transitions, then inverts both select bits after each event to wait for the opposite transition. The unit is programmed and read through a simple word-addressed register port. It has a write strobe and a combinational read.

Top module: `icu_capture`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: Channel x has a 2-bit transition select at byte offset 0x30+4x, in bits [1:0]. Its codes are 0 = off, 1 = low-to-high, 2 = high-to-low and 3 = either. Writes keep only bits [1:0], and the value reads back.
- R3: A channel captures only on the transitions its select code names. With code 0, neither its timestamp nor its pending flag ever changes.
- R4: The control register at 0x50 holds the global run bit at bit 10. When bit 10 is clear, no channel captures and the counter is held at zero.
- R5: The control register holds a divider value p in bits [8:4]. While running, the counter steps by one every p+1 clock cycles. It reads k/(p+1) (rounded down) k cycles after the run bit is set.
- R6: Each input passes through a two-flop synchroniser. The stored timestamp is the counter value held just before the third rising clock edge after the input changes.
- R7: The timestamp of channel x reads from byte offset 0x10+4x, in its low CNT_W bits. The upper bits read zero.
- R8: The pending flag of channel x is bit x+1 of the register at 0x58. A capture sets it, and it stays set until acknowledged. The interrupt mask sits in bits [4:1] at 0x54. `irq` is high exactly when some flag is pending and its mask bit is set.
- R9: Writing to 0x5C clears each pending flag whose bit in [4:1] is written as one, so 0x1FF clears all. A capture in the same cycle as the acknowledge leaves that flag set.
- R10: Channels are independent. A capture on one channel sets only that channel's flag and changes only its timestamp.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Byte address of the register |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Read data for `reg_addr`, combinational |
| cap_in | input | NUM_CH | Asynchronous inputs to be timestamped |
| irq | output | 1 | Masked OR of the pending flags |

## Verification
The bench builds the unit with NUM_CH=4, so all four flag positions and all register offsets are exercised. It uses CNT_W=16, which leaves the upper half of each timestamp word to be checked as zero, and SYNC_STAGES=2, which fixes the exact capture latency used in the expected timestamps. Divider values 0 and 3 are both run, so the rounding of the counter steps and the restart from zero on each enable are visible in the captured values. An acknowledge is timed to land on the same cycle as a new capture.

// File: rtl/icu_pkg.sv
package icu_pkg;
   typedef enum logic [1:0] {
      EDGE_OFF  = 2'd0,
      EDGE_RISE = 2'd1,
      EDGE_FALL = 2'd2,
      EDGE_ANY  = 2'd3
   } edge_sel_e;

   localparam int unsigned MAX_CH       = 4;
   localparam int unsigned OFS_CAP_BASE = 'h10;
   localparam int unsigned OFS_SEL_BASE = 'h30;
   localparam int unsigned OFS_CTRL     = 'h50;
   localparam int unsigned OFS_IMASK    = 'h54;
   localparam int unsigned OFS_PEND     = 'h58;
   localparam int unsigned OFS_ACK      = 'h5C;
   localparam int unsigned RUN_BIT      = 10;
   localparam int unsigned DIV_LSB      = 4;
   localparam int unsigned DIV_W        = 5;
   localparam int unsigned PEND_LSB     = 1;
endpackage

// File: rtl/icu_sync.sv
module icu_sync #(
   parameter int unsigned STAGES = 2
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] pipe_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '0;
      else        pipe_q <= {pipe_q[STAGES-2:0], d};
   end

   assign q = pipe_q[STAGES-1];
endmodule

// File: rtl/icu_timebase.sv
module icu_timebase #(
   parameter int unsigned CNT_W = 32,
   parameter int unsigned DIV_W = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   input  logic [DIV_W-1:0] div,
   output logic [CNT_W-1:0] stamp
);
   logic [DIV_W-1:0] pre_q;
   logic             step;

   // step when the prescale count reaches the divider; >= tolerates a divider lowered while running
   assign step = run && (pre_q >= div);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q <= '0;
         stamp <= '0;
      end else if (!run) begin
         pre_q <= '0;
         stamp <= '0;
      end else begin
         pre_q <= step ? '0 : pre_q + 1'b1;
         stamp <= stamp + CNT_W'(step);
      end
   end

   // R4
   cnt_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !run |=> stamp == '0);

   // R5
   cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(run) |-> (stamp == $past(stamp) || stamp == CNT_W'($past(stamp) + 1'b1)));
endmodule

// File: rtl/icu_channel.sv
module icu_channel #(
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SYNC_STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             pin,
   input  logic             run,
   input  logic [1:0]       sel,
   input  logic [CNT_W-1:0] stamp,
   input  logic             ack,
   output logic [CNT_W-1:0] cap_val,
   output logic             pend
);
   logic pin_s, last_q, rose, fell, hit;

   icu_sync #(.STAGES(SYNC_STAGES)) u_sync (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (pin),
      .q    (pin_s)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) last_q <= 1'b0;
      else        last_q <= pin_s;
   end

   assign rose = pin_s & ~last_q;
   assign fell = ~pin_s & last_q;
   // code bit 0 arms low-to-high, bit 1 arms high-to-low; code 3 arms both
   assign hit  = run & ((sel[0] & rose) | (sel[1] & fell));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cap_val <= '0;
         pend    <= 1'b0;
      end else begin
         if (hit) cap_val <= stamp;
         if (hit)      pend <= 1'b1;
         else if (ack) pend <= 1'b0;
      end
   end

   // R3
   cap_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(run && sel != icu_pkg::EDGE_OFF) |=> $stable(cap_val));

   // R8
   pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && !ack) |=> pend);

   // R9
   pend_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend && ack && !run) |=> !pend);
endmodule

// File: rtl/icu_regs.sv
module icu_regs
   import icu_pkg::*;
#(
   parameter int unsigned NUM_CH = 4,
   parameter int unsigned CNT_W  = 32,
   parameter int unsigned ADDR_W = 8,
   parameter int unsigned DATA_W = 32
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    wr,
   input  logic [ADDR_W-1:0]       addr,
   input  logic [DATA_W-1:0]       wdata,
   output logic [DATA_W-1:0]       rdata,
   input  logic [NUM_CH*CNT_W-1:0] cap_flat,
   input  logic [NUM_CH-1:0]       pend,
   output logic                    run,
   output logic [DIV_W-1:0]        div,
   output logic [NUM_CH*2-1:0]     sel_flat,
   output logic [NUM_CH-1:0]       imask,
   output logic [NUM_CH-1:0]       ack
);
   logic [1:0] sel_q [NUM_CH];
   logic       unused_wdata;

   assign unused_wdata = ^wdata;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         run   <= 1'b0;
         div   <= '0;
         imask <= '0;
         for (int i = 0; i < NUM_CH; i++) sel_q[i] <= 2'b00;
      end else if (wr) begin
         if (addr == ADDR_W'(OFS_CTRL)) begin
            run <= wdata[RUN_BIT];
            div <= wdata[DIV_LSB +: DIV_W];
         end
         if (addr == ADDR_W'(OFS_IMASK)) imask <= wdata[PEND_LSB +: NUM_CH];
         for (int i = 0; i < NUM_CH; i++) begin
            if (addr == ADDR_W'(OFS_SEL_BASE + 4 * i)) sel_q[i] <= wdata[1:0];
         end
      end
   end

   assign ack = (wr && addr == ADDR_W'(OFS_ACK)) ? wdata[PEND_LSB +: NUM_CH] : '0;

   for (genvar g = 0; g < NUM_CH; g++) begin : g_sel
      assign sel_flat[2*g +: 2] = sel_q[g];
   end

   always_comb begin
      rdata = '0;
      if (addr == ADDR_W'(OFS_CTRL)) begin
         rdata[RUN_BIT]           = run;
         rdata[DIV_LSB +: DIV_W]  = div;
      end
      if (addr == ADDR_W'(OFS_IMASK)) rdata[PEND_LSB +: NUM_CH] = imask;
      if (addr == ADDR_W'(OFS_PEND))  rdata[PEND_LSB +: NUM_CH] = pend;
      for (int i = 0; i < NUM_CH; i++) begin
         if (addr == ADDR_W'(OFS_CAP_BASE + 4 * i)) rdata[CNT_W-1:0] = cap_flat[i*CNT_W +: CNT_W];
         if (addr == ADDR_W'(OFS_SEL_BASE + 4 * i)) rdata[1:0]       = sel_q[i];
      end
   end

   // R9
   ack_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !wr |-> ack == '0);
endmodule

// File: rtl/icu_capture.sv
module icu_capture
   import icu_pkg::*;
#(
   parameter int unsigned NUM_CH      = 4,
   parameter int unsigned CNT_W       = 32,
   parameter int unsigned SYNC_STAGES = 2,
   parameter int unsigned ADDR_W      = 8,
   parameter int unsigned DATA_W      = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [ADDR_W-1:0] reg_addr,
   input  logic [DATA_W-1:0] reg_wdata,
   output logic [DATA_W-1:0] reg_rdata,
   input  logic [NUM_CH-1:0] cap_in,
   output logic              irq
);
   localparam int unsigned SEL_W = 2 * NUM_CH;
   localparam int unsigned CAP_W = NUM_CH * CNT_W;

   if (NUM_CH < 1 || NUM_CH > MAX_CH) begin : g_bad_nch
      $error("icu_capture: NUM_CH must be 1..4");
   end
   if (CNT_W < 1 || CNT_W > DATA_W) begin : g_bad_cnt
      $error("icu_capture: CNT_W must be 1..DATA_W");
   end
   if (SYNC_STAGES < 2) begin : g_bad_sync
      $error("icu_capture: SYNC_STAGES must be at least 2");
   end
   if (ADDR_W < 7 || DATA_W < 11) begin : g_bad_bus
      $error("icu_capture: register port too narrow");
   end

   logic                 run;
   logic [DIV_W-1:0]     div;
   logic [CNT_W-1:0]     stamp;
   logic [SEL_W-1:0]     sel_flat;
   logic [CAP_W-1:0]     cap_flat;
   logic [NUM_CH-1:0]    pend, imask, ack;

   icu_regs #(
      .NUM_CH(NUM_CH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
   ) u_regs (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr      (reg_wr),
      .addr    (reg_addr),
      .wdata   (reg_wdata),
      .rdata   (reg_rdata),
      .cap_flat(cap_flat),
      .pend    (pend),
      .run     (run),
      .div     (div),
      .sel_flat(sel_flat),
      .imask   (imask),
      .ack     (ack)
   );

   icu_timebase #(.CNT_W(CNT_W), .DIV_W(DIV_W)) u_tb (
      .clk  (clk),
      .rst_n(rst_n),
      .run  (run),
      .div  (div),
      .stamp(stamp)
   );

   for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
      icu_channel #(.CNT_W(CNT_W), .SYNC_STAGES(SYNC_STAGES)) u_ch (
         .clk    (clk),
         .rst_n  (rst_n),
         .pin    (cap_in[g]),
         .run    (run),
         .sel    (sel_flat[2*g +: 2]),
         .stamp  (stamp),
         .ack    (ack[g]),
         .cap_val(cap_flat[g*CNT_W +: CNT_W]),
         .pend   (pend[g])
      );
   end

   assign irq = |(pend & imask);

   // R8
   irq_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pend == '0) |-> !irq);
endmodule

// File: tb/icu_capture_tb.sv
module icu_capture_tb;
   localparam int NCH = 4;
   localparam int CW  = 16;
   localparam logic [7:0] A_CTRL = 8'h50, A_IMASK = 8'h54, A_PEND = 8'h58, A_ACK = 8'h5C;
   // {ch[7:6], sel[5:4], from[3], to[2], expect_hit[1], spare[0]}
   localparam logic [7:0] VEC [8] = '{
      8'b00010110, 8'b01011000, 8'b10101010, 8'b11100100,
      8'b00111010, 8'b01110110, 8'b10000100, 8'b11001000
   };

   logic clk = 1'b0, rst_n = 1'b0, reg_wr = 1'b0;
   logic [7:0]  reg_addr = '0;
   logic [31:0] reg_wdata = '0, reg_rdata;
   logic [NCH-1:0] cap_in = '0;
   logic irq;

   int checks = 0, fails = 0;
   bit done = 1'b0;
   int unsigned cyc = 0, e_edge = 0, psc_now = 0;
   logic [31:0] last_ts [NCH];

   always #5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   icu_capture #(.NUM_CH(NCH), .CNT_W(CW), .SYNC_STAGES(2), .ADDR_W(8), .DATA_W(32)) u_dut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .cap_in(cap_in), .irq(irq)
   );

   function automatic logic [7:0] a_sel(input int ch);
      return 8'(8'h30 + 4 * ch);
   endfunction
   function automatic logic [7:0] a_cap(input int ch);
      return 8'(8'h10 + 4 * ch);
   endfunction
   function automatic logic [31:0] exp_ts(input int unsigned d0);
      return 32'(((d0 + 2 - e_edge) / (psc_now + 1)) % (1 << CW));
   endfunction

   task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, got, exp);
      end
   endtask

   task automatic wr(input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      if (a == A_CTRL && d[10]) begin
         e_edge  = cyc + 1;
         psc_now = d[8:4];
      end
      reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [7:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_wr = 1'b0; reg_addr = a;
      #1 d = reg_rdata;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [7:0]  v;
      logic [31:0] r;
      int ch;
      int unsigned d0;
      for (int i = 0; i < NCH; i++) last_ts[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      check("R1 irq", {31'b0, irq}, 0);
      rd(A_CTRL, r);  check("R1 ctrl", r, 0);
      rd(A_IMASK, r); check("R1 mask", r, 0);
      rd(A_PEND, r);  check("R1 pend", r, 0);
      for (int i = 0; i < NCH; i++) begin
         rd(a_sel(i), r); check("R1 sel", r, 0);
         rd(a_cap(i), r); check("R1 cap", r, 0);
      end

      // R2 select register width and readback
      wr(a_sel(3), 32'hFF); rd(a_sel(3), r); check("R2 sel masked", r, 3);
      wr(a_sel(3), 32'h2);  rd(a_sel(3), r); check("R2 sel readback", r, 2);
      wr(a_sel(3), 32'h0);

      // R4 run bit clear: no capture
      wr(a_sel(0), 1); wr(A_ACK, 32'h1FF);
      cap_in[0] = 1'b1;
      repeat (6) @(negedge clk);
      rd(A_PEND, r);   check("R4 no pend when stopped", r, 0);
      rd(a_cap(0), r); check("R4 no stamp when stopped", r, 0);
      wr(a_sel(0), 0); cap_in[0] = 1'b0;
      repeat (4) @(negedge clk);

      wr(A_CTRL, 32'h400);
      rd(A_CTRL, r); check("R4 ctrl readback", r, 32'h400);

      // R3 R6 R7 R10 vector walk
      for (int i = 0; i < 8; i++) begin
         v  = VEC[i];
         ch = int'(v[7:6]);
         wr(a_sel(ch), 0);
         cap_in[ch] = v[3];
         repeat (4) @(negedge clk);
         wr(a_sel(ch), {30'b0, v[5:4]});
         wr(A_ACK, 32'h1FF);
         d0 = cyc;
         cap_in[ch] = v[2];
         repeat (6) @(negedge clk);
         rd(A_PEND, r);
         check("R3 R10 pend flag", r, v[1] ? (32'h1 << (ch + 1)) : 32'h0);
         if (v[1]) last_ts[ch] = exp_ts(d0);
         rd(a_cap(ch), r);
         check("R6 R7 stamp", r, last_ts[ch]);
      end

      // R9 acknowledge coinciding with a capture
      wr(a_sel(0), 1); wr(a_sel(3), 1); wr(A_ACK, 32'h1FF);
      cap_in[3] = 1'b1;
      repeat (6) @(negedge clk);
      rd(A_PEND, r); check("R8 pend set ch3", r, 32'h10);
      @(negedge clk);
      d0 = cyc;
      cap_in[0] = 1'b1;
      @(negedge clk);
      wr(A_ACK, 32'h1FF);
      repeat (2) @(negedge clk);
      rd(A_PEND, r);   check("R9 capture beats ack", r, 32'h2);
      rd(a_cap(0), r); check("R6 stamp at ack", r, exp_ts(d0));

      // R8 interrupt masking
      wr(A_IMASK, 0);     check("R8 irq masked", {31'b0, irq}, 0);
      wr(A_IMASK, 32'h2); check("R8 irq raised", {31'b0, irq}, 1);
      wr(A_IMASK, 32'h4); check("R8 irq other mask", {31'b0, irq}, 0);
      rd(A_IMASK, r);     check("R8 mask readback", r, 32'h4);

      // R9 per-bit acknowledge
      wr(A_ACK, 32'h4); rd(A_PEND, r); check("R9 other bit ack", r, 32'h2);
      wr(A_ACK, 32'h2); rd(A_PEND, r); check("R9 bit ack", r, 32'h0);

      // R5 divider of 3 with restart from zero
      wr(A_CTRL, 0);
      wr(A_CTRL, 32'h400 | (32'd3 << 4));
      rd(A_CTRL, r); check("R5 ctrl readback", r, 32'h430);
      wr(a_sel(2), 3); wr(A_ACK, 32'h1FF);
      repeat (10) @(negedge clk);
      d0 = cyc; cap_in[2] = 1'b0;
      repeat (6) @(negedge clk);
      rd(a_cap(2), r); check("R5 divided stamp fall", r, exp_ts(d0));
      repeat (13) @(negedge clk);
      d0 = cyc; cap_in[2] = 1'b1;
      repeat (6) @(negedge clk);
      rd(a_cap(2), r); check("R5 divided stamp rise", r, exp_ts(d0));

      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule